// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

This block is a watchdog timer that sits on a simple word-addressed register bus. Software picks a division ratio and a 12-bit reload field, then turns the timer on. From then on it must write one fixed restart word at regular intervals. If it does not, a scaled down-counter runs out, and the block either drives a reset pulse of selectable length or raises a level interrupt, or both.

The two configuration registers ignore any write that does not carry the correct key in its upper bits. A stray store therefore cannot retune or stop the timer. The restart register works the same way: only one exact data word refreshes the counter. The reload field forms the most significant bits of the down-counter, so a single field step covers a large span of prescaler ticks. A status flag records the timeout and stays set until the next valid restart.

The register slots are selected by addr[3:2]. The mode register is at 0x0, the count register at 0x4, the restart register at 0x8 and the status register at 0xC.

Top module: `wdt_keyed`

## Requirements
- R1: After a synchronous reset, every register reads as zero and both outputs are low.
- R2: A write to 0x0 is stored only if wdata[23:12] equals 0xABC; otherwise it is ignored. The fields are bit 0 run, bit 1 reset-output enable, bit 2 interrupt enable and bits [5:4] pulse-length select. A read returns these fields and zero in every other bit.
- R3: A write to 0x4 is stored only if wdata[31:14] equals 0x248, which means the word contains 0x0092_0000 above bit 13; otherwise it is ignored. The fields are bits [1:0] divider select and bits [13:2] reload. A read returns these fields and zero in every other bit.
- R4: Divider select s makes one prescaler tick every 2^(PRE_BASE+PRE_STEP*s) clocks. With the default parameters these are 8, 64, 512 and 4096 clocks.
- R5: Writing exactly 0x0000_1999 to 0x8 does three things: it loads the counter with reload*2^LOW_BITS, it restarts the prescaler and it clears the status flag. Any other word written there changes nothing.
- R6: When run changes from 0 to 1, the counter is reloaded and the prescaler restarts. While run is 0, the prescaler and the counter hold and no timeout can occur.
- R7: After a reload to N, the timeout fires on prescaler tick N+1. It sets the status flag, and the counter then stays at zero with no further timeout until a valid restart.
- R8: When the reset output is enabled, a timeout drives wdt_rst_o high for 2^(sel+1) clocks, beginning the cycle after the timeout. Encoding 2'b11 gives 16 clocks.
- R9: wdt_irq_o equals the status flag ANDed with the interrupt enable. It stays high until a valid restart or a mode write that clears the enable.
- R10: A read of 0xC returns the status flag in bit 0. A read of 0x8 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | 4 | Byte address; bits [3:2] select the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| wdt_rst_o | output | 1 | Timeout reset pulse |
| wdt_irq_o | output | 1 | Timeout interrupt level |

## Verification
The bench builds the block with PRE_BASE=1, PRE_STEP=1 and LOW_BITS=2. The four divider settings then tick every 2, 4, 8 and 16 clocks, and one step of the reload field is worth four ticks. With these values a full timeout takes tens of clocks instead of millions. All four divider settings, both pulse-length extremes, a disable and re-enable, and the stuck-at-zero state after a timeout therefore each fit in a short run. The timeout cycles are predicted by hand from the requirements and checked exactly. A behavioural model checks both outputs on every clock.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int          RELOAD_W     = 12;
    localparam logic [11:0] MODE_KEY     = 12'hABC;
    localparam logic [17:0] COUNT_KEY    = 18'h00248;
    localparam logic [31:0] RESTART_WORD = 32'h0000_1999;

    typedef enum logic [1:0] {
        SEL_MODE  = 2'd0,
        SEL_COUNT = 2'd1,
        SEL_KICK  = 2'd2,
        SEL_STAT  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [1:0] plen;
        logic       irq_en;
        logic       rst_en;
        logic       run;
    } mode_cfg_t;

    typedef struct packed {
        logic [RELOAD_W-1:0] reload;
        logic [1:0]          div_sel;
    } count_cfg_t;

    function automatic logic mode_key_ok(input logic [31:0] w);
        return w[23:12] == MODE_KEY;
    endfunction

    function automatic logic count_key_ok(input logic [31:0] w);
        return w[31:14] == COUNT_KEY;
    endfunction

    function automatic logic [4:0] pulse_cycles(input logic [1:0] s);
        return 5'd2 << s;
    endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [3:0]  addr,
    input  logic [31:0] wdata,
    output mode_cfg_t   mode_q,
    output count_cfg_t  count_q,
    output logic        kick,
    output logic        arm
);
    reg_sel_e sel;
    logic     mode_wr;
    logic     count_wr;

    assign sel = reg_sel_e'(addr[3:2]);

    always_comb begin
        mode_wr  = wr_en && (sel == SEL_MODE)  && mode_key_ok(wdata);
        count_wr = wr_en && (sel == SEL_COUNT) && count_key_ok(wdata);
        kick     = wr_en && (sel == SEL_KICK)  && (wdata == RESTART_WORD);
        arm      = mode_wr && wdata[0] && !mode_q.run;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            count_q <= '0;
        end else begin
            if (mode_wr) begin
                mode_q.plen   <= wdata[5:4];
                mode_q.irq_en <= wdata[2];
                mode_q.rst_en <= wdata[1];
                mode_q.run    <= wdata[0];
            end
            if (count_wr) begin
                count_q.reload  <= wdata[13:2];
                count_q.div_sel <= wdata[1:0];
            end
        end
    end
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
    parameter int PRE_BASE = 3,
    parameter int PRE_STEP = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       clear,
    input  logic [1:0] div_sel,
    output logic       tick
);
    localparam int PRE_W = PRE_BASE + 3 * PRE_STEP;

    logic [PRE_W-1:0] acc;
    logic [PRE_W-1:0] limit [4];

    generate
        for (genvar g = 0; g < 4; g++) begin : g_limit
            assign limit[g] = {PRE_W{1'b1}} >> (PRE_STEP * (3 - g));
        end
    endgenerate

    assign tick = run && (acc >= limit[div_sel]);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc <= '0;
        end else if (run) begin
            acc <= tick ? '0 : acc + 1'b1;
        end
    end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int LOW_BITS = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                load,
    input  logic                clr,
    input  logic [RELOAD_W-1:0] reload,
    output logic                expire,
    output logic                expired
);
    localparam int CNT_W = RELOAD_W + LOW_BITS;

    logic [CNT_W-1:0] cnt;

    assign expire = tick && !load && !expired && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            expired <= 1'b0;
        end else begin
            if (load) begin
                cnt <= CNT_W'(reload) << LOW_BITS;
            end else if (tick && !expired && (cnt != '0)) begin
                cnt <= cnt - 1'b1;
            end
            if (clr) begin
                expired <= 1'b0;
            end else if (expire) begin
                expired <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fire,
    input  logic [1:0] len_sel,
    output logic       active
);
    logic [4:0] remain;

    assign active = (remain != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (fire) begin
            remain <= pulse_cycles(len_sel);
        end else if (active) begin
            remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
    import wdt_pkg::*;
#(
    parameter int PRE_BASE = 3,
    parameter int PRE_STEP = 3,
    parameter int LOW_BITS = 12
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [3:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        wdt_rst_o,
    output logic        wdt_irq_o
);
    mode_cfg_t  mode_q;
    count_cfg_t count_q;
    logic       kick;
    logic       arm;
    logic       tick;
    logic       expire;
    logic       expired;

    wdt_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .mode_q  (mode_q),
        .count_q (count_q),
        .kick    (kick),
        .arm     (arm)
    );

    wdt_prescale #(
        .PRE_BASE (PRE_BASE),
        .PRE_STEP (PRE_STEP)
    ) u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (mode_q.run),
        .clear   (kick || arm),
        .div_sel (count_q.div_sel),
        .tick    (tick)
    );

    wdt_counter #(
        .LOW_BITS (LOW_BITS)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .load    (kick || arm),
        .clr     (kick),
        .reload  (count_q.reload),
        .expire  (expire),
        .expired (expired)
    );

    wdt_pulse u_pulse (
        .clk     (clk),
        .rst     (rst),
        .fire    (expire && mode_q.rst_en),
        .len_sel (mode_q.plen),
        .active  (wdt_rst_o)
    );

    assign wdt_irq_o = expired && mode_q.irq_en;

    always_comb begin
        unique case (reg_sel_e'(addr[3:2]))
            SEL_MODE:  rdata = {26'd0, mode_q.plen, 1'b0, mode_q.irq_en,
                                mode_q.rst_en, mode_q.run};
            SEL_COUNT: rdata = {18'd0, count_q.reload, count_q.div_sel};
            SEL_KICK:  rdata = 32'd0;
            SEL_STAT:  rdata = {31'd0, expired};
            default:   rdata = 32'd0;
        endcase
    end
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk
    import wdt_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [3:0]  addr,
    input logic [31:0] wdata,
    input mode_cfg_t   mode_q,
    input count_cfg_t  count_q,
    input logic        expired,
    input logic        wdt_rst_o,
    input logic        wdt_irq_o
);
    assert_mode_guard_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr[3:2] == 2'd0 && wdata[23:12] != 12'hABC) |=> $stable(mode_q));

    assert_count_guard_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr[3:2] == 2'd1 && wdata[31:14] != 18'h248) |=> $stable(count_q));

    assert_kick_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr[3:2] == 2'd2 && wdata == 32'h0000_1999) |=> !expired);

    assert_flag_sticks_R7: assert property (@(posedge clk) disable iff (rst)
        (expired && !(wr_en && addr[3:2] == 2'd2)) |=> expired);

    assert_pulse_min_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(wdt_rst_o) |=> wdt_rst_o);

    assert_irq_level_R9: assert property (@(posedge clk) disable iff (rst)
        (wdt_irq_o && !wr_en) |=> wdt_irq_o);
endmodule

bind wdt_keyed wdt_keyed_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .mode_q    (mode_q),
    .count_q   (count_q),
    .expired   (expired),
    .wdt_rst_o (wdt_rst_o),
    .wdt_irq_o (wdt_irq_o)
);

// File: tb/wdt_keyed_tb.sv
module wdt_keyed_tb;
    localparam int PB = 1;
    localparam int PS = 1;
    localparam int LB = 2;
    localparam time PERIOD = 8ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        wdt_rst_o;
    logic        wdt_irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // behavioural reference state
    int m_en, m_rsten, m_irqen, m_plen, m_sel, m_rel, m_pre, m_cnt, m_st, m_pulse;
    int ratio;
    bit tk, zmw, ccw, kk, armv, fire;

    always #(PERIOD / 2) clk = ~clk;

    wdt_keyed #(.PRE_BASE(PB), .PRE_STEP(PS), .LOW_BITS(LB)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .wdt_rst_o (wdt_rst_o),
        .wdt_irq_o (wdt_irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_en = 0; m_rsten = 0; m_irqen = 0; m_plen = 0; m_sel = 0; m_rel = 0;
            m_pre = 0; m_cnt = 0; m_st = 0; m_pulse = 0;
        end else begin
            ratio = 1 << (PB + PS * m_sel);
            tk    = (m_en != 0) && (m_pre >= ratio - 1);
            zmw   = wr_en && addr[3:2] == 2'd0 && wdata[23:12] == 12'hABC;
            ccw   = wr_en && addr[3:2] == 2'd1 && wdata[31:14] == 18'h248;
            kk    = wr_en && addr[3:2] == 2'd2 && wdata == 32'h0000_1999;
            armv  = zmw && wdata[0] && (m_en == 0);
            fire  = tk && !(kk || armv) && (m_st == 0) && (m_cnt == 0);
            if (fire && m_rsten != 0) m_pulse = 2 << m_plen;
            else if (m_pulse > 0) m_pulse--;
            if (kk || armv) begin
                m_cnt = m_rel * (1 << LB);
                m_pre = 0;
            end else begin
                if (m_en != 0) m_pre = tk ? 0 : m_pre + 1;
                if (tk && m_st == 0 && m_cnt > 0) m_cnt--;
            end
            if (kk) m_st = 0;
            else if (fire) m_st = 1;
            if (zmw) begin
                m_en = wdata[0]; m_rsten = wdata[1]; m_irqen = wdata[2]; m_plen = wdata[5:4];
            end
            if (ccw) begin
                m_sel = wdata[1:0]; m_rel = wdata[13:2];
            end
        end
    end

    // per-cycle output comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R8 reset pulse vs model", {31'd0, wdt_rst_o}, {31'd0, m_pulse > 0});
            chk("R9 irq level vs model", {31'd0, wdt_irq_o}, {31'd0, (m_st != 0) && (m_irqen != 0)});
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wdata = 32'd0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string req);
        addr = a;
        #1;
        chk(req, rdata, exp);
    endtask

    task automatic pulse_width(output int w);
        w = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (wdt_rst_o) w++;
            else if (w > 0) break;
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int w;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(4'h0, 32'd0, "R1 mode after reset");
        rd(4'h4, 32'd0, "R1 count after reset");
        rd(4'hC, 32'd0, "R1 status after reset");
        chk("R1 outputs low", {30'd0, wdt_rst_o, wdt_irq_o}, 32'd0);

        // R2/R3 wrong keys are ignored
        wr(4'h0, 32'h00AB_B005);
        rd(4'h0, 32'd0, "R2 bad mode key ignored");
        wr(4'h4, 32'h0093_000C);
        rd(4'h4, 32'd0, "R3 bad count key ignored");

        // valid config: reload 3, divide select 0
        wr(4'h4, 32'h0092_000C);
        rd(4'h4, 32'h0000_000C, "R3 count readback");
        wr(4'h0, 32'h00AB_C005);
        rd(4'h0, 32'h0000_0005, "R2 mode readback, key bits zero");
        // R7/R4: N=12, tick every 2 clocks, timeout on edge 26 after enable
        repeat (25) @(negedge clk);
        chk("R7 no timeout before tick N+1", {31'd0, wdt_irq_o}, 32'd0);
        @(negedge clk);
        chk("R7 timeout on tick N+1", {31'd0, wdt_irq_o}, 32'd1);
        rd(4'hC, 32'd1, "R10 status set");
        rd(4'h8, 32'd0, "R10 restart reads zero");
        repeat (20) @(negedge clk);
        chk("R7 stays timed out", {31'd0, wdt_irq_o}, 32'd1);
        wr(4'h0, 32'h0000_0000);
        rd(4'h0, 32'h0000_0005, "R2 bad key ignored while running");

        // R5 restart word
        wr(4'h8, 32'h0000_1998);
        rd(4'hC, 32'd1, "R5 wrong restart word ignored");
        wr(4'h8, 32'h0000_1999);
        rd(4'hC, 32'd0, "R5 restart clears status");
        chk("R9 irq cleared by restart", {31'd0, wdt_irq_o}, 32'd0);

        // R6 disable holds, re-enable reloads
        wr(4'h0, 32'h00AB_C004);
        repeat (100) @(negedge clk);
        chk("R6 no timeout while disabled", {31'd0, wdt_irq_o}, 32'd0);
        rd(4'hC, 32'd0, "R6 status clear while disabled");
        wr(4'h0, 32'h00AB_C005);
        repeat (25) @(negedge clk);
        chk("R6 reload on enable, early", {31'd0, wdt_irq_o}, 32'd0);
        @(negedge clk);
        chk("R6 reload on enable, timeout", {31'd0, wdt_irq_o}, 32'd1);

        // R4 divide select 2 (8 clocks), reload 1 -> N=4, timeout edge 40
        wr(4'h4, 32'h0092_0006);
        wr(4'h8, 32'h0000_1999);
        repeat (39) @(negedge clk);
        chk("R4 select 2 early", {31'd0, wdt_irq_o}, 32'd0);
        @(negedge clk);
        chk("R4 select 2 timeout", {31'd0, wdt_irq_o}, 32'd1);
        // R4 divide select 3 (16 clocks) -> timeout edge 80
        wr(4'h4, 32'h0092_0007);
        wr(4'h8, 32'h0000_1999);
        repeat (79) @(negedge clk);
        chk("R4 select 3 early", {31'd0, wdt_irq_o}, 32'd0);
        @(negedge clk);
        chk("R4 select 3 timeout", {31'd0, wdt_irq_o}, 32'd1);

        // R8 reset pulse, 16 clocks, irq disabled
        wr(4'h0, 32'h00AB_C033);
        rd(4'h0, 32'h0000_0033, "R2 pulse select readback");
        wr(4'h8, 32'h0000_1999);
        pulse_width(w);
        chk("R8 pulse width 16", w, 32'd16);
        rd(4'hC, 32'd1, "R10 status after reset-mode timeout");
        chk("R9 irq masked when disabled", {31'd0, wdt_irq_o}, 32'd0);
        wr(4'h0, 32'h00AB_C003);
        wr(4'h8, 32'h0000_1999);
        pulse_width(w);
        chk("R8 pulse width 2", w, 32'd2);

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule